// File: doc/BRIEF.md
# Mesh Merge Sorter

The block merges two ascending key sequences into one ascending sequence on a grid of ROWS x COLS compare-exchange cells. Each input sequence carries ROWS*COLS/2 unsigned keys. A load strobe captures both sequences into the grid in a single cycle. A start pulse then runs two passes of odd-even transposition. The first pass works inside every column, between vertically adjacent cells. The second pass works inside every row, between horizontally adjacent cells. When the row pass ends, a one-cycle done flag marks that the grid holds the merged sequence.

The placement at load time is what makes two passes sufficient. The first sequence fills the upper half of the grid row by row, left to right. The second sequence fills the lower half row by row, right to left. After the column pass, the count of small keys in any two columns differs by at most one. The row pass then leaves the grid sorted in plain row-major order. The whole merge takes ROWS + COLS clock cycles. ROWS must be even and both dimensions at least 2.

Top module: `mesh_merge_sorter`

## Requirements
- R1: After reset, busy and done are low and every key on sortedKeys is zero.
- R2: When the block is idle, loadEn writes the grid on the next clock edge. Grid cell (r, c) appears on sortedKeys at key index r*COLS+c, and key k occupies bits [k*KEY_W +: KEY_W]. First-sequence key i goes to index i. Second-sequence key i goes to row ROWS/2 + i/COLS, column COLS-1-(i mod COLS).
- R3: A start pulse while idle raises busy on the next cycle. Done is high, and busy low, exactly ROWS+COLS cycles after the edge that accepted start.
- R4: The column pass lasts ROWS cycles, pairing even-indexed rows with the row below on even steps and odd-indexed rows on odd steps; the upper cell keeps the minimum. At its end every column is non-decreasing from top to bottom.
- R5: The row pass lasts COLS cycles with the same even/odd alternation; the west cell keeps the minimum and the east cell the maximum. At done every row is non-decreasing from west to east.
- R6: At done, sortedKeys read in index order is the ascending merge of the two loaded sequences. This holds for every 0/1 input pattern and for arbitrary ascending inputs.
- R7: A start pulse while busy is ignored: the running merge keeps its timing, and no second done follows.
- R8: A loadEn pulse while busy is ignored: the result is the merge of the keys loaded before start.
- R9: Done stays high for a single cycle. While the block is idle and loadEn is low, sortedKeys does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Capture both input sequences into the grid (idle only) |
| aKeys | input | ROWS*COLS/2*KEY_W | First ascending sequence, key i at bits [i*KEY_W +: KEY_W] |
| bKeys | input | ROWS*COLS/2*KEY_W | Second ascending sequence, same packing |
| start | input | 1 | Launch the merge (idle only) |
| busy | output | 1 | Merge in progress |
| done | output | 1 | One-cycle pulse: grid holds the merged result |
| sortedKeys | output | ROWS*COLS*KEY_W | Grid contents in row-major key order |

## Verification
On every cycle, the checker tracks:
- that done is a single-cycle pulse landing exactly ROWS+COLS cycles after an accepted start, which also catches a restart caused by a start while busy;
- that every column is ordered when the column pass ends;
- that rows and the whole grid are ordered at done;
- that the grid is frozen while idle without a load.

Only the bench scenarios can show the following:
- that the output is the same multiset as the input, namely the true merge of the loaded sequences;
- the exact load placement;
- that a load during a run leaves the result untouched.

The bench sweeps every pair of ascending 0/1 sequences on the default 4 x 4 grid.

// File: rtl/mesh_merge_pkg.sv
package mesh_merge_pkg;

  // Strobes from the control sequencer to the cell grid.
  typedef struct packed {
    logic load;     // capture both input sequences
    logic colStep;  // one odd-even step between vertical neighbours
    logic rowStep;  // one odd-even step between horizontal neighbours
    logic oddPair;  // 0: pairs start at even index, 1: at odd index
  } meshStrobes_t;

endpackage

// File: rtl/mesh_merge_ctrl.sv
module mesh_merge_ctrl
  import mesh_merge_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         loadEn,
  output meshStrobes_t strobes,
  output logic         busy,
  output logic         done
);

  localparam int MAX_DIM = (ROWS > COLS) ? ROWS : COLS;
  localparam int CNT_W   = $clog2(MAX_DIM + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_COL, ST_ROW} phase_t;

  phase_t          phase;
  logic [CNT_W-1:0] stepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        ST_IDLE: begin
          if (start) begin
            phase   <= ST_COL;
            stepCnt <= '0;
          end
        end
        ST_COL: begin
          if (stepCnt == CNT_W'(ROWS - 1)) begin
            phase   <= ST_ROW;
            stepCnt <= '0;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        ST_ROW: begin
          if (stepCnt == CNT_W'(COLS - 1)) begin
            phase   <= ST_IDLE;
            stepCnt <= '0;
            done    <= 1'b1;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy            = (phase != ST_IDLE);
    strobes.load    = loadEn && (phase == ST_IDLE);
    strobes.colStep = (phase == ST_COL);
    strobes.rowStep = (phase == ST_ROW);
    strobes.oddPair = stepCnt[0];
  end

endmodule

// File: rtl/mesh_merge_grid.sv
module mesh_merge_grid
  import mesh_merge_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int KEY_W = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  meshStrobes_t                    strobes,
  input  logic [(ROWS*COLS/2)*KEY_W-1:0]  aKeys,
  input  logic [(ROWS*COLS/2)*KEY_W-1:0]  bKeys,
  output logic [ROWS*COLS*KEY_W-1:0]      gridKeys
);

  localparam int HALF_ROWS = ROWS / 2;

  logic [KEY_W-1:0] cellQ   [ROWS][COLS];
  logic [KEY_W-1:0] cellNxt [ROWS][COLS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam logic ROW_ODD = (r % 2) == 1;
      localparam logic COL_ODD = (c % 2) == 1;

      logic [KEY_W-1:0] upV, dnV, westV, eastV, loadV, nextV;

      // Border cells see themselves as partner, so min/max leaves them unchanged.
      if (r > 0) begin : g_up
        assign upV = cellQ[r-1][c];
      end else begin : g_up_edge
        assign upV = cellQ[r][c];
      end
      if (r < ROWS - 1) begin : g_dn
        assign dnV = cellQ[r+1][c];
      end else begin : g_dn_edge
        assign dnV = cellQ[r][c];
      end
      if (c > 0) begin : g_west
        assign westV = cellQ[r][c-1];
      end else begin : g_west_edge
        assign westV = cellQ[r][c];
      end
      if (c < COLS - 1) begin : g_east
        assign eastV = cellQ[r][c+1];
      end else begin : g_east_edge
        assign eastV = cellQ[r][c];
      end

      // Upper half: first sequence left to right; lower half: second sequence right to left.
      if (r < HALF_ROWS) begin : g_load_a
        assign loadV = aKeys[(r*COLS + c)*KEY_W +: KEY_W];
      end else begin : g_load_b
        assign loadV = bKeys[((r - HALF_ROWS)*COLS + (COLS - 1 - c))*KEY_W +: KEY_W];
      end

      always_comb begin
        nextV = cellQ[r][c];
        if (strobes.load) begin
          nextV = loadV;
        end else if (strobes.colStep) begin
          if (strobes.oddPair == ROW_ODD) begin
            nextV = (dnV < cellQ[r][c]) ? dnV : cellQ[r][c];   // upper keeps min
          end else begin
            nextV = (upV > cellQ[r][c]) ? upV : cellQ[r][c];   // lower keeps max
          end
        end else if (strobes.rowStep) begin
          if (strobes.oddPair == COL_ODD) begin
            nextV = (eastV < cellQ[r][c]) ? eastV : cellQ[r][c]; // west keeps min
          end else begin
            nextV = (westV > cellQ[r][c]) ? westV : cellQ[r][c]; // east keeps max
          end
        end
      end

      assign cellNxt[r][c] = nextV;
      assign gridKeys[(r*COLS + c)*KEY_W +: KEY_W] = cellQ[r][c];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cellQ <= '{default: '0};
    end else begin
      cellQ <= cellNxt;
    end
  end

endmodule

// File: rtl/mesh_merge_sorter.sv
module mesh_merge_sorter
  import mesh_merge_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int KEY_W = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            loadEn,
  input  logic [(ROWS*COLS/2)*KEY_W-1:0]  aKeys,
  input  logic [(ROWS*COLS/2)*KEY_W-1:0]  bKeys,
  input  logic                            start,
  output logic                            busy,
  output logic                            done,
  output logic [ROWS*COLS*KEY_W-1:0]      sortedKeys
);

  meshStrobes_t strobes;

  mesh_merge_ctrl #(
    .ROWS(ROWS),
    .COLS(COLS)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .loadEn (loadEn),
    .strobes(strobes),
    .busy   (busy),
    .done   (done)
  );

  mesh_merge_grid #(
    .ROWS (ROWS),
    .COLS (COLS),
    .KEY_W(KEY_W)
  ) i_grid (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .aKeys   (aKeys),
    .bKeys   (bKeys),
    .gridKeys(sortedKeys)
  );

endmodule

// File: rtl/mesh_merge_checker.sv
module mesh_merge_checker #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int KEY_W = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       loadEn,
  input logic                       start,
  input logic                       busy,
  input logic                       done,
  input logic [ROWS*COLS*KEY_W-1:0] sortedKeys
);

  localparam int CELLS  = ROWS * COLS;
  localparam int CYC_W  = $clog2(ROWS + COLS + 2) + 1;

  logic [CYC_W-1:0] runCyc;
  logic allSorted, colsSorted, rowsSorted;

  // Cycles since the edge that accepted start (1 right after that edge).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCyc <= '0;
    end else if (start && !busy) begin
      runCyc <= CYC_W'(1);
    end else if (busy) begin
      runCyc <= runCyc + 1'b1;
    end
  end

  always_comb begin
    allSorted  = 1'b1;
    colsSorted = 1'b1;
    rowsSorted = 1'b1;
    for (int k = 0; k < CELLS - 1; k++) begin
      if (sortedKeys[k*KEY_W +: KEY_W] > sortedKeys[(k+1)*KEY_W +: KEY_W]) allSorted = 1'b0;
    end
    for (int r = 0; r < ROWS - 1; r++) begin
      for (int c = 0; c < COLS; c++) begin
        if (sortedKeys[(r*COLS + c)*KEY_W +: KEY_W] >
            sortedKeys[((r+1)*COLS + c)*KEY_W +: KEY_W]) colsSorted = 1'b0;
      end
    end
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS - 1; c++) begin
        if (sortedKeys[(r*COLS + c)*KEY_W +: KEY_W] >
            sortedKeys[(r*COLS + c + 1)*KEY_W +: KEY_W]) rowsSorted = 1'b0;
      end
    end
  end

  a_r1_idle_out_of_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!busy && !done));

  a_r3_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !done));

  // Also covers R7: a restart on a busy start would shift this count.
  a_r3_done_on_time: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runCyc == CYC_W'(ROWS + COLS + 1)));

  a_r4_columns_ordered: assert property (@(posedge clk) disable iff (!rstN)
    (busy && runCyc == CYC_W'(ROWS + 1)) |-> colsSorted);

  a_r5_rows_ordered: assert property (@(posedge clk) disable iff (!rstN)
    done |-> rowsSorted);

  a_r6_merged_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> allSorted);

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !loadEn) |=> $stable(sortedKeys));

endmodule

bind mesh_merge_sorter mesh_merge_checker #(
  .ROWS (ROWS),
  .COLS (COLS),
  .KEY_W(KEY_W)
) i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .loadEn    (loadEn),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .sortedKeys(sortedKeys)
);

// File: tb/test_mesh_merge_sorter.sv
module test_mesh_merge_sorter;

  localparam int ROWS  = 4;
  localparam int COLS  = 4;
  localparam int KEY_W = 8;
  localparam int CELLS = ROWS * COLS;
  localparam int HALF  = CELLS / 2;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    loadEn = 1'b0;
  logic                    start = 1'b0;
  logic [HALF*KEY_W-1:0]   aKeys = '0;
  logic [HALF*KEY_W-1:0]   bKeys = '0;
  logic                    busy, done;
  logic [CELLS*KEY_W-1:0]  sortedKeys;

  int checks = 0;
  int failures = 0;

  logic [KEY_W-1:0] aArr [HALF];
  logic [KEY_W-1:0] bArr [HALF];
  logic [KEY_W-1:0] expArr [CELLS];

  always #2.5 clk = ~clk;

  mesh_merge_sorter #(
    .ROWS(ROWS), .COLS(COLS), .KEY_W(KEY_W)
  ) i_mesh_merge_sorter (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .aKeys(aKeys), .bKeys(bKeys),
    .start(start), .busy(busy), .done(done), .sortedKeys(sortedKeys)
  );

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%s expected=%s", tag, act, exp);
    end
  endtask

  function automatic logic [KEY_W-1:0] outKey(input int k);
    return sortedKeys[k*KEY_W +: KEY_W];
  endfunction

  function automatic string outStr();
    string s = "";
    for (int k = 0; k < CELLS; k++) s = {s, $sformatf("%0d ", outKey(k))};
    return s;
  endfunction

  function automatic string expStr();
    string s = "";
    for (int k = 0; k < CELLS; k++) s = {s, $sformatf("%0d ", expArr[k])};
    return s;
  endfunction

  function automatic bit outMatches();
    for (int k = 0; k < CELLS; k++) if (outKey(k) !== expArr[k]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit columnsOrdered();
    for (int r = 0; r < ROWS - 1; r++)
      for (int c = 0; c < COLS; c++)
        if (outKey(r*COLS + c) > outKey((r+1)*COLS + c)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit rowsOrdered();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS - 1; c++)
        if (outKey(r*COLS + c) > outKey(r*COLS + c + 1)) return 1'b0;
    return 1'b1;
  endfunction

  // Reference two-pointer merge of the ascending inputs.
  task automatic buildMerge();
    int i = 0;
    int j = 0;
    for (int k = 0; k < CELLS; k++) begin
      if (j >= HALF || (i < HALF && aArr[i] <= bArr[j])) begin
        expArr[k] = aArr[i]; i++;
      end else begin
        expArr[k] = bArr[j]; j++;
      end
    end
  endtask

  task automatic packInputs();
    for (int i = 0; i < HALF; i++) begin
      aKeys[i*KEY_W +: KEY_W] = aArr[i];
      bKeys[i*KEY_W +: KEY_W] = bArr[i];
    end
  endtask

  task automatic randomAscending();
    aArr[0] = KEY_W'($urandom % 20);
    bArr[0] = KEY_W'($urandom % 20);
    for (int i = 1; i < HALF; i++) begin
      aArr[i] = aArr[i-1] + KEY_W'($urandom % 20);
      bArr[i] = bArr[i-1] + KEY_W'($urandom % 20);
    end
  endtask

  // mode 0: plain, 1: extra start while busy (R7), 2: load while busy (R8)
  task automatic runMerge(input int mode, input string tag);
    bit earlyDone = 1'b0;
    bit colOk = 1'b1;
    logic [CELLS*KEY_W-1:0] held;
    buildMerge();
    @(negedge clk);
    packInputs();
    loadEn = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
    start  = 1'b1;
    @(negedge clk);                       // start accepted on the previous edge
    start = 1'b0;
    check(busy === 1'b1, {"R3 busy after start ", tag}, $sformatf("%b", busy), "1");
    for (int k = 1; k <= ROWS + COLS; k++) begin
      @(negedge clk);
      start  = (mode == 1) && (k == 2);
      loadEn = (mode == 2) && (k == 2);
      if (loadEn) begin
        aKeys = '1;
        bKeys = '0;
      end
      if (k < ROWS + COLS && done) earlyDone = 1'b1;
      if (k == ROWS) colOk = columnsOrdered();
    end
    start  = 1'b0;
    loadEn = 1'b0;
    check(colOk, {"R4 columns ordered after column pass ", tag}, outStr(), "each column ascending");
    check(done === 1'b1 && busy === 1'b0 && !earlyDone, {"R3 done timing ", tag},
          $sformatf("done=%b busy=%b early=%b", done, busy, earlyDone), "done=1 busy=0 early=0");
    check(rowsOrdered(), {"R5 rows ordered at done ", tag}, outStr(), "each row ascending");
    check(outMatches(), {"R6 merge result ", tag}, outStr(), expStr());
    if (mode == 2) check(outMatches(), {"R8 load while busy ignored ", tag}, outStr(), expStr());
    held = sortedKeys;
    @(negedge clk);
    check(done === 1'b0 && sortedKeys === held, {"R9 single done and hold ", tag},
          $sformatf("done=%b", done), "done=0, keys unchanged");
    if (mode == 1) begin
      bit extra = 1'b0;
      for (int k = 0; k < ROWS + COLS + 2; k++) begin
        @(negedge clk);
        if (done || busy) extra = 1'b1;
      end
      check(!extra, {"R7 start while busy ignored ", tag}, $sformatf("extra=%b", extra), "0");
    end
  endtask

  task automatic testReset();
    bit zero = 1'b1;
    for (int k = 0; k < CELLS; k++) if (outKey(k) !== '0) zero = 1'b0;
    check(busy === 1'b0 && done === 1'b0 && zero, "R1 reset state",
          $sformatf("busy=%b done=%b keys=%s", busy, done, outStr()), "0 0 all zero");
  endtask

  task automatic testPlacement();
    randomAscending();
    for (int i = 0; i < HALF; i++) begin
      expArr[i] = aArr[i];
      expArr[HALF + (i / COLS)*COLS + (COLS - 1 - (i % COLS))] = bArr[i];
    end
    @(negedge clk);
    packInputs();
    loadEn = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
    check(outMatches() && busy === 1'b0, "R2 load placement", outStr(), expStr());
  endtask

  task automatic testExhaustiveBinary();
    for (int na = 0; na <= HALF; na++) begin
      for (int nb = 0; nb <= HALF; nb++) begin
        for (int i = 0; i < HALF; i++) begin
          aArr[i] = (i >= HALF - na) ? KEY_W'(1) : KEY_W'(0);
          bArr[i] = (i >= HALF - nb) ? KEY_W'(1) : KEY_W'(0);
        end
        runMerge(0, $sformatf("R6 binary ones=%0d/%0d", na, nb));
      end
    end
  endtask

  task automatic testRandom();
    for (int n = 0; n < 20; n++) begin
      randomAscending();
      runMerge(0, $sformatf("random #%0d", n));
    end
  endtask

  task automatic testDuplicates();
    for (int i = 0; i < HALF; i++) begin
      aArr[i] = KEY_W'(7);
      bArr[i] = KEY_W'(i < HALF/2 ? 7 : 9);
    end
    runMerge(0, "equal keys");
  endtask

  task automatic testStartWhileBusy();
    randomAscending();
    runMerge(1, "R7 scenario");
  endtask

  task automatic testLoadWhileBusy();
    randomAscending();
    runMerge(2, "R8 scenario");
  endtask

  task automatic testIdleHold();
    logic [CELLS*KEY_W-1:0] held = sortedKeys;
    bit moved = 1'b0;
    aKeys = '1;
    bKeys = '1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (sortedKeys !== held) moved = 1'b1;
    end
    check(!moved, "R9 idle hold without load", $sformatf("moved=%b", moved), "0");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPlacement();
    testExhaustiveBinary();
    testRandom();
    testDuplicates();
    testStartWhileBusy();
    testLoadWhileBusy();
    testIdleHold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule